// File: doc/BRIEF.md
# Converter Mode and Ready Controller

This block is the control core behind the serial interface of a delta-sigma converter. It holds the configuration byte, which contains a ready flag, a one-shot/continuous mode bit, a two-bit rate field and four bits of auxiliary settings that it stores without acting on them. It also holds the result word. An internal cycle timer stands in for the analog modulator. Its period depends on the rate field, and each time it expires it produces a new result. The result is the number of conversions completed since reset.

A serial front end sends two kinds of event. A configuration write carries a full byte. A read-complete strobe says that the host has consumed the current result. The ready flag is low while an unread new result is waiting and high otherwise. A write can start a conversion. A read affects the flag differently in the two modes: in continuous mode it raises the flag, and in one-shot mode the flag stays low until the next start command. Reset puts the block in continuous mode with no valid result.

Top module: `adc_ready_ctrl`

## Requirements
- R1: After reset the readback byte is 0x90 (ready=1, continuous), the result is 0, and continuous conversion is running.
- R2: A conversion takes 8 << rate clock cycles, where rate is readback/write bits [3:2]. Rates 0 to 3 give 8, 16, 32 and 64 cycles, counted from reset release or from the write edge that started it.
- R3: A write with bit 4 = 1 restarts the timer and runs continuous conversion, whatever the value of bit 7.
- R4: A write with bit 4 = 0 and bit 7 = 1 starts exactly one conversion. Ready reads 1 until that conversion completes, then reads 0, and no further conversion follows.
- R5: A write with bit 4 = 0 and bit 7 = 0 stores the other fields without starting anything and leaves ready unchanged. A one-shot conversion already in progress still completes on time. Continuous conversion stops.
- R6: Every completion replaces the result with the previous result plus 1 and clears ready, whether or not the old result was read.
- R7: In continuous mode, a read strobe sets ready to 1 on the next cycle.
- R8: In one-shot mode, a read strobe leaves ready at 0.
- R9: When a completion and a read strobe fall on the same cycle, the completion wins and ready reads 0.
- R10: A starting write (R3 or R4) on the same cycle as a completion discards that completion: the result keeps its value and a full new period begins.
- R11: The readback byte holds ready at bit 7 and mode at bit 4. The rate at bits [3:2], together with bits [6:5] and [1:0], reads back exactly as last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte written with cfg_wr |
| rd_done | input | 1 | One-cycle strobe: the current result has been read |
| result_out | output | DATA_W | Latest conversion result |
| cfg_rdata | output | 8 | Configuration readback byte including the ready flag |

## Verification
The timer is exercised in free-running continuous mode with the result left unread, with periodic reads, and across several rate values. Together these separate the period arithmetic from the overwrite behaviour. Single conversions are started both with and without a later non-starting write in flight, which shows whether such a write disturbs an ongoing conversion or stops a continuous one. Reads and starting writes are placed on the exact completion cycle so that the two priority rules are tested apart from the ordinary read and write paths.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

  localparam int CFG_W  = 8;
  localparam int RATE_W = 2;

  // Bit order matters: software decodes ready at bit 7 and mode at bit 4.
  typedef struct packed {
    logic              rdy;
    logic [1:0]        aux_hi;
    logic              cont;
    logic [RATE_W-1:0] rate;
    logic [1:0]        aux_lo;
  } cfg_byte_t;

  localparam cfg_byte_t CFG_RESET = '{rdy: 1'b1, aux_hi: 2'b00, cont: 1'b1,
                                      rate: '0, aux_lo: 2'b00};

endpackage

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
  parameter int BASE_CYCLES = 8,
  parameter int RATE_SHIFT  = 1,
  parameter int RATE_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              done_o
);

  localparam int N_RATES = 2 ** RATE_W;
  localparam int MAX_P   = BASE_CYCLES << (RATE_SHIFT * (N_RATES - 1));
  localparam int CNT_W   = $clog2(MAX_P);

  logic [CNT_W-1:0] last_tbl [N_RATES];
  logic [CNT_W-1:0] cnt_q;

  genvar g;
  generate
    for (g = 0; g < N_RATES; g++) begin : g_period
      assign last_tbl[g] = CNT_W'((BASE_CYCLES << (RATE_SHIFT * g)) - 1);
    end
  endgenerate

  // >= so a mid-conversion rate change to a shorter period still ends.
  assign done_o = run_i && !restart_i && (cnt_q >= last_tbl[rate_i]);

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i || done_o) cnt_q <= '0;
    else                                      cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/adc_mode_ctrl.sv
module adc_mode_ctrl
  import adc_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_i,
  input  cfg_byte_t wdata_i,
  input  logic      rd_i,
  input  logic      done_i,
  output cfg_byte_t cfg_o,
  output logic      run_o,
  output logic      restart_o
);

  cfg_byte_t cfg_q;
  logic      run_q;
  logic      start_cont, start_once, hold_write;

  assign start_cont = wr_i && wdata_i.cont;
  assign start_once = wr_i && !wdata_i.cont && wdata_i.rdy;
  assign hold_write = wr_i && !wdata_i.cont && !wdata_i.rdy;
  assign restart_o  = start_cont || start_once;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
      run_q <= 1'b1;
    end else begin
      if (wr_i) begin
        cfg_q.aux_hi <= wdata_i.aux_hi;
        cfg_q.cont   <= wdata_i.cont;
        cfg_q.rate   <= wdata_i.rate;
        cfg_q.aux_lo <= wdata_i.aux_lo;
      end

      // Ready: one-shot start > completion > consuming read.
      if (start_once)             cfg_q.rdy <= 1'b1;
      else if (done_i)            cfg_q.rdy <= 1'b0;
      else if (rd_i && cfg_q.cont) cfg_q.rdy <= 1'b1;

      if (restart_o)              run_q <= 1'b1;
      else if (hold_write)        run_q <= run_q && !cfg_q.cont && !done_i;
      else if (done_i && !cfg_q.cont) run_q <= 1'b0;
    end
  end

  assign cfg_o = cfg_q;
  assign run_o = run_q;

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  output logic [DATA_W-1:0] result_o
);

  logic [DATA_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (rst)         res_q <= '0;
    else if (done_i) res_q <= res_q + DATA_W'(1);
  end

  assign result_o = res_q;

endmodule

// File: rtl/adc_ready_ctrl.sv
module adc_ready_ctrl
  import adc_cfg_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int BASE_CYCLES = 8,
  parameter int RATE_SHIFT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  input  logic              rd_done,
  output logic [DATA_W-1:0] result_out,
  output logic [7:0]        cfg_rdata
);

  cfg_byte_t cfg_q;
  logic      conv_run, conv_restart, conv_done;

  adc_mode_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (cfg_wr),
    .wdata_i   (cfg_byte_t'(cfg_wdata)),
    .rd_i      (rd_done),
    .done_i    (conv_done),
    .cfg_o     (cfg_q),
    .run_o     (conv_run),
    .restart_o (conv_restart)
  );

  adc_rate_timer #(
    .BASE_CYCLES (BASE_CYCLES),
    .RATE_SHIFT  (RATE_SHIFT),
    .RATE_W      (RATE_W)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run_i     (conv_run),
    .restart_i (conv_restart),
    .rate_i    (cfg_q.rate),
    .done_o    (conv_done)
  );

  adc_result_reg #(.DATA_W(DATA_W)) u_result (
    .clk      (clk),
    .rst      (rst),
    .done_i   (conv_done),
    .result_o (result_out)
  );

  assign cfg_rdata = cfg_q;

endmodule

// File: rtl/adc_ready_ctrl_chk.sv
module adc_ready_ctrl_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [7:0]        cfg_wdata,
  input logic              rd_done,
  input logic              conv_done,
  input logic [DATA_W-1:0] result_out,
  input logic [7:0]        cfg_rdata
);

  AST_DONE_CLEARS_RDY: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> !cfg_rdata[7]); // R6

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> $stable(result_out)); // R6

  AST_RESULT_STEPS: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> (result_out == DATA_W'($past(result_out) + 1'b1))); // R6

  AST_CONT_READ_SETS: assert property (@(posedge clk) disable iff (rst)
    (rd_done && cfg_rdata[4] && !conv_done && !cfg_wr) |=> cfg_rdata[7]); // R7

  AST_ONCE_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !cfg_rdata[4] && !conv_done && !cfg_wr) |=> $stable(cfg_rdata[7])); // R8

  AST_ONCE_START: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_wdata[4] && cfg_wdata[7]) |=> (cfg_rdata[7] && !cfg_rdata[4])); // R4

  AST_START_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && (cfg_wdata[4] || cfg_wdata[7])) |=> $stable(result_out)); // R10

endmodule

bind adc_ready_ctrl adc_ready_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .rd_done    (rd_done),
  .conv_done  (conv_done),
  .result_out (result_out),
  .cfg_rdata  (cfg_rdata)
);

// File: tb/adc_ready_ctrl_test.sv
module adc_ready_ctrl_test;

  localparam int DATA_W = 18;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_wr = 1'b0;
  logic [7:0]        cfg_wdata = 8'h00;
  logic              rd_done = 1'b0;
  logic [DATA_W-1:0] result_out;
  logic [7:0]        cfg_rdata;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  adc_ready_ctrl #(.DATA_W(DATA_W)) uut (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .rd_done    (rd_done),
    .result_out (result_out),
    .cfg_rdata  (cfg_rdata)
  );

  // Behavioural reference model, advanced on every rising edge.
  int m_rdy, m_mode, m_rate, m_low7, m_run, m_cnt, m_res;

  always @(posedge clk) begin
    if (rst) begin
      m_rdy = 1; m_mode = 1; m_rate = 0; m_low7 = 7'h10; m_run = 1; m_cnt = 0; m_res = 0;
    end else begin
      int period, dn, st_once, st_cont;
      period  = 8 << m_rate;
      st_cont = (cfg_wr && cfg_wdata[4]) ? 1 : 0;
      st_once = (cfg_wr && !cfg_wdata[4] && cfg_wdata[7]) ? 1 : 0;
      dn = (m_run != 0 && st_cont == 0 && st_once == 0 && m_cnt >= period - 1) ? 1 : 0;
      if (st_once != 0)              m_rdy = 1;
      else if (dn != 0)              m_rdy = 0;
      else if (rd_done && m_mode != 0) m_rdy = 1;
      if (st_cont != 0 || st_once != 0) m_run = 1;
      else if (cfg_wr)               m_run = (m_run != 0 && m_mode == 0 && dn == 0) ? 1 : 0;
      else if (dn != 0 && m_mode == 0) m_run = 0;
      if (dn != 0) m_res = (m_res + 1) % (1 << DATA_W);
      m_cnt = (dn != 0 || st_cont != 0 || st_once != 0) ? 0 : m_cnt + 1;
      if (cfg_wr) begin
        m_mode = cfg_wdata[4];
        m_rate = cfg_wdata[3:2];
        m_low7 = cfg_wdata[6:0];
      end
      if (m_run == 0) m_cnt = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Whole-output comparison against the model at every falling edge.
  always @(negedge clk) begin
    if (!rst && !ended) begin
      check("R11 model readback", int'(cfg_rdata), (m_rdy << 7) | m_low7);
      check("R6 model result", int'(result_out), m_res);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] b);
    cfg_wr = 1'b1; cfg_wdata = b;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = 8'h00;
  endtask

  task automatic pulse_rd();
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    check("R1 reset readback", int'(cfg_rdata), 8'h90);
    check("R1 reset result", int'(result_out), 0);
    rst = 1'b0;
    step(7);
    check("R2 no completion before 8 cycles", int'(cfg_rdata[7]), 1);
    step(1);
    check("R6 first completion clears ready", int'(cfg_rdata[7]), 0);
    check("R2 first result at cycle 8", int'(result_out), 1);

    pulse_rd();
    check("R7 continuous read sets ready", int'(cfg_rdata[7]), 1);
    step(15);
    check("R6 unread results overwritten", int'(result_out), 3);
    check("R6 ready low after completion", int'(cfg_rdata[7]), 0);

    write_cfg(8'h7D);   // R3: continuous, bit 7 clear, rate 3
    check("R11 fields read back", int'(cfg_rdata), 8'h7D);
    step(63);
    check("R2 rate 3 not yet done", int'(result_out), 3);
    step(1);
    check("R2 rate 3 done at 64", int'(result_out), 4);

    write_cfg(8'h0C);   // hold write stops continuous
    check("R5 hold write readback", int'(cfg_rdata), 8'h0C);
    step(100);
    check("R5 continuous stopped", int'(result_out), 4);

    write_cfg(8'h80);   // one-shot, rate 0
    check("R4 ready high while converting", int'(cfg_rdata), 8'h80);
    step(7);
    check("R4 still converting", int'(result_out), 4);
    step(1);
    check("R4 one-shot result", int'(result_out), 5);
    check("R4 ready low after one-shot", int'(cfg_rdata[7]), 0);
    pulse_rd();
    check("R8 one-shot read keeps ready low", int'(cfg_rdata[7]), 0);
    step(40);
    check("R4 no further conversion", int'(result_out), 5);

    write_cfg(8'h80);
    step(2);
    write_cfg(8'h03);   // hold write during one-shot
    check("R5 readback during one-shot", int'(cfg_rdata), 8'h83);
    step(4);
    check("R5 one-shot still pending", int'(result_out), 5);
    step(1);
    check("R5 one-shot finishes on time", int'(result_out), 6);

    write_cfg(8'h90);
    step(7);
    pulse_rd();         // read lands on completion edge
    check("R9 completion beats read", int'(cfg_rdata[7]), 0);
    check("R9 result updated", int'(result_out), 7);

    step(7);
    write_cfg(8'hF0);   // start write lands on completion edge
    check("R10 completion discarded", int'(result_out), 7);
    check("R10 readback after restart", int'(cfg_rdata), 8'h70);
    step(7);
    check("R10 full new period", int'(result_out), 7);
    step(1);
    check("R10 next completion", int'(result_out), 8);

    write_cfg(8'h14);   // R3: continuous, rate 1
    step(15);
    check("R2 rate 1 not yet done", int'(result_out), 8);
    step(1);
    check("R2 rate 1 done at 16", int'(result_out), 9);

    finish_run();
  end

endmodule